// File: doc/BRIEF.md
# Stream Backpressure Adapter

This block sits behind a streaming function that is built as a next-state combinational process feeding a state register. It receives two copies of the function's output beat: the combinational next value and the registered current value. From these it produces the external output stream and the ready signal that goes back to the function. Each beat carries valid, start-of-packet, end-of-packet, a sync marker and a data word.

Two boolean parameters pick one of three modes. With ready use switched off, the registered copy is passed straight through and the ready signal back to the function is held high. In the combinational-ready mode, the next value is loaded into one output register whenever that register is empty or downstream accepts. In the registered-ready mode, the registered copy is written into a small shift buffer whose head is the output. The ready signal back to the function then comes from a flop, which keeps the downstream ready path short for timing.

On the output side a beat counts as delivered on a rising edge where `out_valid` and `dn_ready` are both high. An output beat that is not accepted is held unchanged.

Top module: `stream_fc_wrap`

## Requirements
- R1: With `USE_READY` = 0, `up_ready` is always 1 and every output field equals the matching `cur_*` input in the same cycle.
- R2: In combinational-ready mode (`USE_READY` = 1, `PIPE_READY` = 0), `up_ready` equals `dn_ready OR NOT out_valid` in every cycle.
- R3: In combinational-ready mode, a beat on the `nxt_*` inputs with `nxt_valid` high in a cycle where `up_ready` is high appears on the outputs after the next rising edge. A beat offered while `up_ready` is low is discarded.
- R4: In both registered modes, if `out_valid` is high and `dn_ready` is low, then after the next edge `out_valid` is still high and the data, sop, eop and sync outputs are unchanged.
- R5: In registered-ready mode (`USE_READY` = 1, `PIPE_READY` = 1), `up_ready` is a flop. The sender may raise `cur_valid` only in a cycle that follows one where `up_ready` was high. After each edge, `up_ready` is high exactly when the number of beats held plus the previous `up_ready` value is at most `BUF_DEPTH`-1.
- R6: In registered-ready mode, every beat presented with `cur_valid` high leaves the output exactly once, in arrival order. No more than `BUF_DEPTH` beats are ever held.
- R7: In both registered modes, with `dn_ready` held high and the sender offering a beat whenever allowed, one beat is delivered per cycle once the first beat has arrived (registered-ready mode needs `BUF_DEPTH` of at least 3 for this).
- R8: Sop, eop and sync stay attached to their data word. In the bench's stimulus, sop marks data values with low two bits 0, eop marks low two bits 3, and sync marks low four bits 0.
- R9: While `rst` is high on an edge, all held beats are dropped and `out_valid` goes low. `up_ready` is then 1 in combinational-ready mode and 0 in registered-ready mode.
- R10: In combinational-ready mode, when the output beat is accepted and no new beat is loaded, `out_valid` is low after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nxt_valid | input | 1 | Valid of the function's combinational next beat |
| nxt_sop | input | 1 | Start of packet, next beat |
| nxt_eop | input | 1 | End of packet, next beat |
| nxt_sync | input | 1 | Sync marker, next beat |
| nxt_data | input | DATA_W | Data word, next beat |
| cur_valid | input | 1 | Valid of the function's registered beat |
| cur_sop | input | 1 | Start of packet, registered beat |
| cur_eop | input | 1 | End of packet, registered beat |
| cur_sync | input | 1 | Sync marker, registered beat |
| cur_data | input | DATA_W | Data word, registered beat |
| dn_ready | input | 1 | Downstream accepts the output beat |
| up_ready | output | 1 | Ready returned to the function |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | Output start of packet |
| out_eop | output | 1 | Output end of packet |
| out_sync | output | 1 | Output sync marker |
| out_data | output | DATA_W | Output data word |

## Verification
The assertions check several properties on every clock. In both registered modes, a stalled output stays frozen. In registered-ready mode, a beat arrives only one cycle after `up_ready` was high, and a full buffer is never written without a pop. In combinational-ready mode, a captured beat surfaces on the next edge and an accepted beat with nothing behind it leaves the output empty. Other behaviour is shown only by the bench's scenarios. These are the exact `up_ready` sequence of the registered mode, exactly-once in-order delivery under random backpressure, sustained full rate with ready held high, the markers travelling with their data, and the state after a reset that lands mid-stream.

// File: rtl/fcw_pkg.sv
package fcw_pkg;

  typedef struct packed {
    logic sync;
    logic sop;
    logic eop;
  } fcw_ctrl_t;

  localparam int FCW_CTRL_W = 3;

  typedef enum logic [1:0] {
    FCW_MODE_OFF,
    FCW_MODE_COMB,
    FCW_MODE_REG
  } fcw_mode_e;

  function automatic fcw_mode_e fcw_pick_mode(input bit use_rdy, input bit pipe_rdy);
    if (!use_rdy)     return FCW_MODE_OFF;
    else if (pipe_rdy) return FCW_MODE_REG;
    else               return FCW_MODE_COMB;
  endfunction

endpackage

// File: rtl/fcw_pipe_stage.sv
// Single output register loaded from the combinational next beat.
module fcw_pipe_stage #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_bus,
  output logic         up_ready,
  input  logic         dn_ready,
  output logic         out_valid,
  output logic [W-1:0] out_bus
);

  logic         vld_q;
  logic [W-1:0] bus_q;
  logic         load;

  // the register may take a new beat when it is empty or being drained
  assign load     = dn_ready | ~vld_q;
  assign up_ready = load;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      bus_q <= '0;
    end else if (load) begin
      vld_q <= in_valid;
      bus_q <= in_bus;
    end
  end

  assign out_valid = vld_q;
  assign out_bus   = bus_q;

  // R3: an accepted beat is on the output after one edge
  p_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (up_ready && in_valid) |=> (out_valid && out_bus == $past(in_bus)));

  // R4: a stalled beat does not move
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !dn_ready) |=> (out_valid && $stable(out_bus)));

  // R10: draining with nothing behind leaves the stage empty
  p_drain_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && dn_ready && !in_valid) |=> !out_valid);

endmodule

// File: rtl/fcw_skid_stage.sv
// Shift buffer behind a registered ready; entry 0 is the output register.
module fcw_skid_stage #(
  parameter int W     = 11,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_bus,
  output logic         up_ready,
  input  logic         dn_ready,
  output logic         out_valid,
  output logic [W-1:0] out_bus
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  slot_q [DEPTH];
  logic [W-1:0]  slot_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d, wr_idx;
  logic          vld_q, rdy_q, rdy_d, pop;

  assign pop = vld_q & dn_ready;

  always_comb begin
    cnt_d  = cnt_q + CW'(in_valid) - CW'(pop);
    wr_idx = cnt_q - CW'(pop);
    for (int i = 0; i < DEPTH; i++) begin
      slot_d[i] = slot_q[i];
      if (pop && i < DEPTH - 1) slot_d[i] = slot_q[(i + 1) % DEPTH];
    end
    if (in_valid && int'(wr_idx) < DEPTH) slot_d[wr_idx[AW-1:0]] = in_bus;
    // one more grant is safe only if held beats plus the beat already
    // granted still leave a free entry
    rdy_d = (int'(cnt_d) + int'(rdy_q)) <= DEPTH - 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
      rdy_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      cnt_q  <= cnt_d;
      vld_q  <= (cnt_d != '0);
      rdy_q  <= rdy_d;
      slot_q <= slot_d;
    end
  end

  assign up_ready  = rdy_q;
  assign out_valid = vld_q;
  assign out_bus   = slot_q[0];

  // R5: beats arrive only one cycle after a grant
  p_arrival_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> $past(up_ready));

  // R6: a full buffer is never written without a pop
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !pop) |-> (int'(cnt_q) < DEPTH));

  // R4: a stalled head does not move
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !dn_ready) |=> (out_valid && $stable(out_bus)));

endmodule

// File: rtl/stream_fc_wrap.sv
module stream_fc_wrap
  import fcw_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit USE_READY  = 1'b1,
  parameter bit PIPE_READY = 1'b0,
  parameter int BUF_DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nxt_valid,
  input  logic              nxt_sop,
  input  logic              nxt_eop,
  input  logic              nxt_sync,
  input  logic [DATA_W-1:0] nxt_data,
  input  logic              cur_valid,
  input  logic              cur_sop,
  input  logic              cur_eop,
  input  logic              cur_sync,
  input  logic [DATA_W-1:0] cur_data,
  input  logic              dn_ready,
  output logic              up_ready,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_sync,
  output logic [DATA_W-1:0] out_data
);

  localparam int        BUS_W = DATA_W + FCW_CTRL_W;
  localparam fcw_mode_e MODE  = fcw_pick_mode(USE_READY, PIPE_READY);

  fcw_ctrl_t        nxt_ctrl, cur_ctrl, out_ctrl;
  logic [BUS_W-1:0] nxt_bus, cur_bus, out_bus;

  assign nxt_ctrl = '{sync: nxt_sync, sop: nxt_sop, eop: nxt_eop};
  assign cur_ctrl = '{sync: cur_sync, sop: cur_sop, eop: cur_eop};
  assign nxt_bus  = {nxt_ctrl, nxt_data};
  assign cur_bus  = {cur_ctrl, cur_data};

  generate
    if (MODE == FCW_MODE_OFF) begin : g_off
      assign up_ready  = 1'b1;
      assign out_valid = cur_valid;
      assign out_bus   = cur_bus;
      logic unused_off;
      assign unused_off = ^{clk, rst, dn_ready, nxt_valid, nxt_bus};
    end else if (MODE == FCW_MODE_COMB) begin : g_comb
      fcw_pipe_stage #(.W(BUS_W)) u_pipe (
        .clk(clk), .rst(rst),
        .in_valid(nxt_valid), .in_bus(nxt_bus),
        .up_ready(up_ready), .dn_ready(dn_ready),
        .out_valid(out_valid), .out_bus(out_bus)
      );
      logic unused_comb;
      assign unused_comb = ^{cur_valid, cur_bus};
    end else begin : g_reg
      fcw_skid_stage #(.W(BUS_W), .DEPTH(BUF_DEPTH)) u_skid (
        .clk(clk), .rst(rst),
        .in_valid(cur_valid), .in_bus(cur_bus),
        .up_ready(up_ready), .dn_ready(dn_ready),
        .out_valid(out_valid), .out_bus(out_bus)
      );
      logic unused_reg;
      assign unused_reg = ^{nxt_valid, nxt_bus};
    end
  endgenerate

  assign out_ctrl = out_bus[BUS_W-1 -: FCW_CTRL_W];
  assign out_data = out_bus[DATA_W-1:0];
  assign out_sync = out_ctrl.sync;
  assign out_sop  = out_ctrl.sop;
  assign out_eop  = out_ctrl.eop;

endmodule

// File: tb/tb_stream_fc_wrap.sv
`timescale 1ns/1ps
module tb_stream_fc_wrap;

  localparam int DW = 8;
  localparam int DEPTH = 3;
  localparam int BW = DW + 3;
  localparam int NCYC = 1150;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dn = 1'b0;
  always #4 clk = ~clk;

  // combinational-ready instance
  logic cv, cs, cp, ce; logic [DW-1:0] cd;
  logic c_ur, c_ov, c_os, c_op, c_oe; logic [DW-1:0] c_od;
  // registered-ready instance
  logic rv, rs, rp, re; logic [DW-1:0] rd;
  logic r_ur, r_ov, r_os, r_op, r_oe; logic [DW-1:0] r_od;
  // pass-through instance
  logic pv, ps, pp, pe; logic [DW-1:0] pd;
  logic p_ur, p_ov, p_os, p_op, p_oe; logic [DW-1:0] p_od;

  stream_fc_wrap #(.DATA_W(DW)) dut (
    .clk(clk), .rst(rst),
    .nxt_valid(cv), .nxt_sop(cp), .nxt_eop(ce), .nxt_sync(cs), .nxt_data(cd),
    .cur_valid(1'b0), .cur_sop(1'b0), .cur_eop(1'b0), .cur_sync(1'b0), .cur_data('0),
    .dn_ready(dn), .up_ready(c_ur),
    .out_valid(c_ov), .out_sop(c_op), .out_eop(c_oe), .out_sync(c_os), .out_data(c_od));

  stream_fc_wrap #(.DATA_W(DW), .PIPE_READY(1'b1), .BUF_DEPTH(DEPTH)) dut_reg (
    .clk(clk), .rst(rst),
    .nxt_valid(1'b0), .nxt_sop(1'b0), .nxt_eop(1'b0), .nxt_sync(1'b0), .nxt_data('0),
    .cur_valid(rv), .cur_sop(rp), .cur_eop(re), .cur_sync(rs), .cur_data(rd),
    .dn_ready(dn), .up_ready(r_ur),
    .out_valid(r_ov), .out_sop(r_op), .out_eop(r_oe), .out_sync(r_os), .out_data(r_od));

  stream_fc_wrap #(.DATA_W(DW), .USE_READY(1'b0)) dut_pass (
    .clk(clk), .rst(rst),
    .nxt_valid(1'b0), .nxt_sop(1'b0), .nxt_eop(1'b0), .nxt_sync(1'b0), .nxt_data('0),
    .cur_valid(pv), .cur_sop(pp), .cur_eop(pe), .cur_sync(ps), .cur_data(pd),
    .dn_ready(dn), .up_ready(p_ur),
    .out_valid(p_ov), .out_sop(p_op), .out_eop(p_oe), .out_sync(p_os), .out_data(p_od));

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // beat k: data = k, sop on low bits 00, eop on low bits 11, sync on low nibble 0
  function automatic logic [BW-1:0] beat(input int k);
    logic [DW-1:0] d;
    d = DW'(k);
    return {d[3:0] == 4'h0, d[1:0] == 2'b00, d[1:0] == 2'b11, d};
  endfunction

  function automatic bit markers_ok(input logic [BW-1:0] b);
    return b == beat(int'(b[DW-1:0]));
  endfunction

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    // reference state
    bit mv; logic [BW-1:0] md;
    logic [BW-1:0] q[$];
    bit mr, prev_rdy;
    int ck, rk, cexp, rexp;
    logic [BW-1:0] cin, rin, pin, cout, rout, pout;
    bit prev_cov, prev_rov, prev_dn, prev_rst;
    logic [BW-1:0] prev_cout, prev_rout;
    int thr_c, thr_r;

    mv = 0; md = '0; mr = 0; prev_rdy = 0;
    ck = 0; rk = 0; cexp = 0; rexp = 0;
    prev_cov = 0; prev_rov = 0; prev_dn = 0; prev_rst = 1;
    prev_cout = '0; prev_rout = '0;
    thr_c = 0; thr_r = 0;
    {cv, cs, cp, ce, cd} = '0; {rv, rs, rp, re, rd} = '0; {pv, ps, pp, pe, pd} = '0;

    @(negedge clk);
    for (int n = 0; n < NCYC; n++) begin
      bit full, stall;
      full  = (n >= 4 && n < 204);
      stall = (n >= 704 && n < 740);
      rst = (n < 4) || (n >= 740 && n < 744);
      dn = full ? 1'b1 : (stall ? 1'b0 : 1'($urandom_range(0, 1)));

      cin = beat(ck);
      cv = rst ? 1'b0 : (full ? 1'b1 : ($urandom_range(0, 9) < 7));
      {cs, cp, ce, cd} = cin;
      rin = beat(rk);
      rv = rst ? 1'b0 : (prev_rdy && (full ? 1'b1 : ($urandom_range(0, 9) < 7)));
      {rs, rp, re, rd} = rin;
      pin = BW'($urandom);
      pv = 1'($urandom_range(0, 1));
      {ps, pp, pe, pd} = pin;
      #1;

      cout = {c_os, c_op, c_oe, c_od};
      rout = {r_os, r_op, r_oe, r_od};
      pout = {p_os, p_op, p_oe, p_od};

      // R1: pass-through
      check(p_ur == 1'b1, "R1 up_ready", p_ur, 1);
      check({p_ov, pout} == {pv, pin}, "R1 out", {p_ov, pout}, {pv, pin});

      if (n == 3 || n == 743) begin
        check(c_ov == 1'b0, "R9 comb out_valid", c_ov, 0);
        check(c_ur == 1'b1, "R9 comb up_ready", c_ur, 1);
        check(r_ov == 1'b0, "R9 reg out_valid", r_ov, 0);
        check(r_ur == 1'b0, "R9 reg up_ready", r_ur, 0);
      end

      if (!prev_rst) begin
        // combinational-ready instance
        check(c_ur == (dn | ~mv), "R2 up_ready", c_ur, dn | ~mv);
        check(c_ov == mv, "R10 out_valid", c_ov, mv);
        if (mv) check(cout == md, "R3 out beat", cout, md);
        if (prev_cov && !prev_dn)
          check(c_ov && cout == prev_cout, "R4 comb hold", cout, prev_cout);
        // registered-ready instance
        check(r_ur == mr, "R5 up_ready", r_ur, mr);
        check(r_ov == (q.size() > 0), "R6 out_valid", r_ov, q.size() > 0);
        if (q.size() > 0) check(rout == q[0], "R6 out beat", rout, q[0]);
        check(q.size() <= DEPTH, "R6 occupancy", q.size(), DEPTH);
        if (prev_rov && !prev_dn)
          check(r_ov && rout == prev_rout, "R4 reg hold", rout, prev_rout);
      end

      // delivered beats: order and markers
      if (!rst && c_ov && dn) begin
        check(int'(c_od) == (cexp & 8'hff), "R8 comb order", c_od, cexp & 8'hff);
        check(markers_ok(cout), "R8 comb markers", cout, beat(int'(c_od)));
        cexp++;
      end
      if (!rst && r_ov && dn) begin
        check(int'(r_od) == (rexp & 8'hff), "R8 reg order", r_od, rexp & 8'hff);
        check(markers_ok(rout), "R8 reg markers", rout, beat(int'(r_od)));
        rexp++;
      end

      // R7: full rate with ready held high
      if (n >= 10 && n < 204) begin
        check(c_ov == 1'b1, "R7 comb rate", c_ov, 1);
        check(r_ov == 1'b1, "R7 reg rate", r_ov, 1);
        thr_c += int'(c_ov); thr_r += int'(r_ov);
      end
      if (n == 204) begin
        check(thr_c == 194, "R7 comb count", thr_c, 194);
        check(thr_r == 194, "R7 reg count", thr_r, 194);
      end

      // advance reference to the coming edge
      prev_cov = c_ov; prev_rov = r_ov; prev_dn = dn; prev_rst = rst;
      prev_cout = cout; prev_rout = rout;
      if (rst) begin
        mv = 0; md = '0; q.delete(); mr = 0; prev_rdy = 0;
        ck = 0; rk = 0; cexp = 0; rexp = 0;
      end else begin
        bit newr;
        if (cv && (dn || !mv)) ck++;
        if (dn || !mv) begin mv = cv; md = cin; end
        prev_rdy = mr;
        if (q.size() > 0 && dn) void'(q.pop_front());
        if (rv) begin q.push_back(rin); rk++; end
        newr = (q.size() + int'(mr)) <= DEPTH - 1;
        mr = newr;
      end
      @(negedge clk);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule